// File: doc/BRIEF.md
# HDLC Receive Frame Validator

This block receives a serial HDLC bit stream, one bit for each cycle in which the rate strobe `rx_en` is high. It finds the opening and closing flags and removes the zeros that the transmitter inserted after five ones. It checks each frame against the CRC-16 frame check sequence and filters it by address. Frames that pass the filter are written byte by byte into a receive FIFO. Each FIFO entry carries a tag that marks a plain data byte, a good end of packet or a bad end of packet. The two FCS bytes are stored after the payload, so the host can read them.

Frames of fewer than 25 bits between flags leave no trace. Frames of 25 to 31 bits, and frames that end on a partial byte or fail the FCS check, are kept but tagged bad. A run of seven ones cuts a frame off. The bytes that frame has already delivered stay in the FIFO, the last of them is tagged bad, and the bad-frame interrupt is raised. Four sticky interrupt sources (nearly full, overflow, good end of packet, bad frame) are masked onto one interrupt line.

Top module: `hdlc_rx_frame`

## Requirements
- R1: A 0 received after exactly six 1s is a flag that delimits frames. A 0 received after exactly five 1s is removed. Payload bytes, including bytes that contain runs of five or more 1s, reach the FIFO unchanged, least significant bit first on the line.
- R2: Seven or more consecutive 1s abort the current frame and put the receiver into hunt until the next flag.
- R3: A frame of fewer than 25 bits between its flags causes no FIFO write and no interrupt.
- R4: A frame of 25 to 31 bits, or one whose length is not a whole number of bytes, is written to the FIFO with its last entry tagged bad (2'b10).
- R5: The CRC-16 (polynomial x^16+x^12+x^5+1, reflected, preset to all ones) is run over all frame bits. A residue of 0xF0B8 tags the last entry good end of packet (2'b01). Any other residue tags it bad (2'b10). Data entries carry 2'b00.
- R6: The two received FCS bytes are stored after the payload, the low-order byte first.
- R7: `addr_mode` 0 accepts every frame. Mode 1 accepts a frame whose first byte equals `addr0` or is 0xFF. Modes 2 and 3 accept a frame whose first two bytes equal `addr0`,`addr1`, or whose first byte is 0xFF. A rejected frame writes nothing and raises nothing.
- R8: The FIFO holds 32 entries. A write into a full FIFO is dropped and sets the overflow source. An occupancy of 28 or more sets the nearly-full source.
- R9: The interrupt sources are held in `irq_stat`: bit 0 nearly full, bit 1 overflow, bit 2 good end of packet, bit 3 bad frame. A 1 in `irq_clr` clears a bit. `irq` is high while any bit is set under a 1 in `irq_mask`.
- R10: `rx_bit` is ignored in cycles where `rx_en` is low.
- R11: An abort after 25 or more frame bits of an accepted frame keeps the bytes already delivered, tags the last delivered entry bad (2'b10) and sets the bad-frame source. At most the final partly assembled byte is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Rate strobe: one line bit per high cycle |
| rx_bit | input | 1 | Serial line bit |
| addr_mode | input | 2 | Address filter mode |
| addr0 | input | 8 | First address byte to match |
| addr1 | input | 8 | Second address byte (dual mode) |
| rd_en | input | 1 | Pop one FIFO entry |
| rd_data | output | 8 | Popped byte, valid with rd_valid |
| rd_tag | output | 2 | Popped entry tag |
| rd_valid | output | 1 | rd_data/rd_tag hold a popped entry |
| fifo_empty | output | 1 | FIFO holds no entry |
| irq_mask | input | 4 | Per-source interrupt enable |
| irq_clr | input | 4 | Per-source clear |
| irq_stat | output | 4 | Sticky interrupt sources |
| irq | output | 1 | Masked interrupt line |

## Verification
A line bit shows up at the byte assembler two cycles after its strobe. Because the delimiter uses a seven-bit delay, a frame closes at the cycle after the final flag bit is detected. The three held-back bytes then drain into the FIFO over three cycles. The matching `irq_stat` bit follows one cycle after the end event, and `irq` one cycle after that. A pop returns `rd_data`/`rd_tag`/`rd_valid` on the clock edge after `rd_en` is sampled. So the bench idles at least ten cycles after every closing flag before it looks at the FIFO or the interrupts. It samples every pop and status at the falling edge after the registering edge.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam logic [1:0] TAG_DATA = 2'b00;
  localparam logic [1:0] TAG_GOOD = 2'b01;
  localparam logic [1:0] TAG_BAD  = 2'b10;

  localparam logic [1:0] AM_ANY = 2'd0;
  localparam logic [1:0] AM_ONE = 2'd1;

  localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_LS = 16'h8408;
  localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;
  localparam logic [7:0]  BROADCAST   = 8'hFF;

  localparam int KEEP_BITS = 25;
  localparam int GOOD_BITS = 32;
  localparam int HOLD_BYTES = 3;

  localparam int IRQ_NF  = 0;
  localparam int IRQ_OVF = 1;
  localparam int IRQ_EOP = 2;
  localparam int IRQ_BAD = 3;
  localparam int IRQ_N   = 4;

  function automatic logic [15:0] crc_next(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return fb ? ((c >> 1) ^ CRC_POLY_LS) : (c >> 1);
  endfunction

  function automatic logic addr_pass(input logic [1:0] mode, input logic [7:0] b0,
                                     input logic [7:0] b1, input logic [7:0] a0,
                                     input logic [7:0] a1);
    if (mode == AM_ANY) return 1'b1;
    if (b0 == BROADCAST) return 1'b1;
    if (mode == AM_ONE) return b0 == a0;
    return (b0 == a0) && (b1 == a1);
  endfunction
endpackage

// File: rtl/hdlc_rx_delin.sv
module hdlc_rx_delin #(
  parameter int FLAG_ONES = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_en,
  input  logic rx_bit,
  output logic o_bit_vld,
  output logic o_bit,
  output logic o_flag,
  output logic o_abort
);
  localparam int DLY = FLAG_ONES + 1;
  localparam int OW  = $clog2(FLAG_ONES + 2);
  localparam int FW  = $clog2(DLY + 1);
  localparam logic [OW-1:0] N_STUFF = OW'(FLAG_ONES - 1);
  localparam logic [OW-1:0] N_FLAG  = OW'(FLAG_ONES);
  localparam logic [OW-1:0] N_ABORT = OW'(FLAG_ONES + 1);
  localparam logic [FW-1:0] FILL_MAX = FW'(DLY);

  logic [OW-1:0]  ones;
  logic [DLY-1:0] dly;
  logic [FW-1:0]  fill;
  logic           push_en;

  always_comb begin
    push_en = 1'b0;
    if (rx_en) begin
      if (rx_bit) push_en = (ones <= N_STUFF);
      else        push_en = (ones != N_STUFF) && (ones != N_FLAG);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ones      <= '0;
      dly       <= '0;
      fill      <= '0;
      o_bit_vld <= 1'b0;
      o_bit     <= 1'b0;
      o_flag    <= 1'b0;
      o_abort   <= 1'b0;
    end else begin
      o_bit_vld <= 1'b0;
      o_flag    <= 1'b0;
      o_abort   <= 1'b0;
      if (rx_en) begin
        if (rx_bit) begin
          if (ones == N_FLAG) begin
            o_abort <= 1'b1;
            ones    <= N_ABORT;
            fill    <= '0;
          end else if (ones != N_ABORT) begin
            ones <= ones + 1'b1;
          end
        end else begin
          ones <= '0;
          if (ones == N_FLAG) begin
            o_flag <= 1'b1;
            fill   <= '0;
          end
        end
        if (push_en) begin
          dly <= {dly[DLY-2:0], rx_bit};
          if (fill == FILL_MAX) begin
            o_bit_vld <= 1'b1;
            o_bit     <= dly[DLY-1];
          end else begin
            fill <= fill + 1'b1;
          end
        end
      end
    end
  end

  // R10: a line bit only leaves the delimiter after a strobed cycle
  p_strobe_gate_r10: assert property (@(posedge clk) disable iff (rst)
    (o_bit_vld || o_flag || o_abort) |-> $past(rx_en));
  // R2: an abort leaves the ones counter in the hunt value
  p_abort_hunt_r2: assert property (@(posedge clk) disable iff (rst)
    o_abort |-> ones == N_ABORT);
endmodule

// File: rtl/hdlc_rx_collect.sv
module hdlc_rx_collect
  import hdlc_rx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_vld,
  input  logic       bit_in,
  input  logic       flag_in,
  input  logic       abort_in,
  input  logic [1:0] addr_mode,
  input  logic [7:0] addr0,
  input  logic [7:0] addr1,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic [1:0] wr_tag,
  output logic       ev_good,
  output logic       ev_bad
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [1:0] HOLD_L = 2'(HOLD_BYTES);

  logic             in_frame;
  logic [CNT_W-1:0] bitcnt;
  logic [7:0]       sreg;
  logic [2:0]       nbit;
  logic [15:0]      crc;
  logic [7:0]       q  [HOLD_BYTES];
  logic [1:0]       qcnt;
  logic             started, keep_r;
  logic [7:0]       fl [HOLD_BYTES];
  logic [1:0]       fl_left;
  logic             fl_bad;

  logic       keep_now, long_enough, frame_bad, byte_done;
  logic [7:0] new_byte;

  always_comb begin
    keep_now    = started ? keep_r : addr_pass(addr_mode, q[0], q[1], addr0, addr1);
    long_enough = bitcnt >= CNT_W'(KEEP_BITS);
    frame_bad   = (bitcnt < CNT_W'(GOOD_BITS)) || (bitcnt[2:0] != 3'd0) || (crc != CRC_RESIDUE);
    byte_done   = bit_vld && in_frame && (nbit == 3'd7);
    new_byte    = {bit_in, sreg[7:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      bitcnt   <= '0;
      sreg     <= '0;
      nbit     <= '0;
      crc      <= CRC_PRESET;
      qcnt     <= '0;
      started  <= 1'b0;
      keep_r   <= 1'b0;
      fl_left  <= '0;
      fl_bad   <= 1'b0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
      wr_tag   <= TAG_DATA;
      ev_good  <= 1'b0;
      ev_bad   <= 1'b0;
      for (int i = 0; i < HOLD_BYTES; i++) begin
        q[i]  <= '0;
        fl[i] <= '0;
      end
    end else begin
      wr_en   <= 1'b0;
      ev_good <= 1'b0;
      ev_bad  <= 1'b0;
      if (fl_left != 2'd0) begin
        wr_en   <= 1'b1;
        wr_data <= fl[0];
        wr_tag  <= (fl_left == 2'd1) ? (fl_bad ? TAG_BAD : TAG_GOOD) : TAG_DATA;
        for (int i = 0; i < HOLD_BYTES - 1; i++) fl[i] <= fl[i+1];
        fl_left <= fl_left - 2'd1;
      end
      if (flag_in || abort_in) begin
        if (in_frame && long_enough && keep_now) begin
          for (int i = 0; i < HOLD_BYTES; i++) fl[i] <= q[i];
          fl_left <= HOLD_L;
          fl_bad  <= abort_in || frame_bad;
          ev_good <= flag_in && !frame_bad;
          ev_bad  <= abort_in || frame_bad;
        end
        in_frame <= flag_in;
        bitcnt   <= '0;
        nbit     <= '0;
        crc      <= CRC_PRESET;
        qcnt     <= '0;
        started  <= 1'b0;
      end else if (bit_vld && in_frame) begin
        sreg <= new_byte;
        crc  <= crc_next(crc, bit_in);
        nbit <= nbit + 3'd1;
        if (bitcnt != CNT_MAX) bitcnt <= bitcnt + 1'b1;
        if (byte_done) begin
          if (qcnt == HOLD_L) begin
            for (int i = 0; i < HOLD_BYTES - 1; i++) q[i] <= q[i+1];
            q[HOLD_BYTES-1] <= new_byte;
            if (!started) begin
              started <= 1'b1;
              keep_r  <= addr_pass(addr_mode, q[0], q[1], addr0, addr1);
            end
            if (keep_now) begin
              wr_en   <= 1'b1;
              wr_data <= q[0];
              wr_tag  <= TAG_DATA;
            end
          end else begin
            q[qcnt] <= new_byte;
            qcnt    <= qcnt + 2'd1;
          end
        end
      end
    end
  end

  // R3: a frame below the keep length ends with no event
  p_short_silent_r3: assert property (@(posedge clk) disable iff (rst)
    (flag_in && in_frame && !long_enough) |=> !ev_good && !ev_bad);
  // R11: an abort on a long accepted frame starts a bad-tagged drain
  p_abort_bad_r11: assert property (@(posedge clk) disable iff (rst)
    (abort_in && in_frame && long_enough && keep_now) |=> (fl_left == HOLD_L) && fl_bad && ev_bad);
  // R5: the good and bad end events never coincide
  p_one_verdict_r5: assert property (@(posedge clk) disable iff (rst)
    !(ev_good && ev_bad));
  // R1: the drain and a streaming byte never compete for the write port
  p_one_writer_r1: assert property (@(posedge clk) disable iff (rst)
    (fl_left != 2'd0) |-> !(byte_done && qcnt == HOLD_L && !flag_in && !abort_in));
endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo #(
  parameter int DEPTH    = 32,
  parameter int WIDTH    = 10,
  parameter int NF_LEVEL = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_q,
  output logic             rd_vld,
  output logic             empty,
  output logic             near_full,
  output logic             ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0]   CNT_FULL = (AW+1)'(DEPTH);
  localparam logic [AW:0]   CNT_NF   = (AW+1)'(NF_LEVEL);
  localparam logic [AW-1:0] LAST     = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [AW:0]      cnt;
  logic             full, do_wr, do_rd;

  always_comb begin
    full      = (cnt == CNT_FULL);
    empty     = (cnt == '0);
    near_full = (cnt >= CNT_NF);
    do_wr     = wr_en && !full;
    do_rd     = rd_en && !empty;
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
    if (do_rd) rd_q <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
      rd_vld <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      rd_vld <= do_rd;
      ovf    <= wr_en && full;
      if (do_wr) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R8: occupancy never exceeds the depth
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_FULL);
  // R8: a write into a full FIFO leaves the occupancy unchanged
  p_full_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en) |=> cnt == $past(cnt));
  // R8: popped data appears only for a requested pop
  p_read_ack_r8: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> $past(rd_en));
endmodule

// File: rtl/hdlc_rx_frame.sv
module hdlc_rx_frame
  import hdlc_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  parameter int NF_LEVEL   = 28,
  parameter int CNT_W      = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_en,
  input  logic       rx_bit,
  input  logic [1:0] addr_mode,
  input  logic [7:0] addr0,
  input  logic [7:0] addr1,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic [1:0] rd_tag,
  output logic       rd_valid,
  output logic       fifo_empty,
  input  logic [3:0] irq_mask,
  input  logic [3:0] irq_clr,
  output logic [3:0] irq_stat,
  output logic       irq
);
  logic       b_vld, b_val, f_evt, a_evt;
  logic       w_en, ev_good, ev_bad, near_full, ovf;
  logic [7:0] w_data;
  logic [1:0] w_tag;
  logic [9:0] r_q;
  logic [IRQ_N-1:0] irq_set;

  hdlc_rx_delin u_delin (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rx_bit(rx_bit),
    .o_bit_vld(b_vld), .o_bit(b_val), .o_flag(f_evt), .o_abort(a_evt)
  );

  hdlc_rx_collect #(.CNT_W(CNT_W)) u_collect (
    .clk(clk), .rst(rst), .bit_vld(b_vld), .bit_in(b_val),
    .flag_in(f_evt), .abort_in(a_evt), .addr_mode(addr_mode),
    .addr0(addr0), .addr1(addr1), .wr_en(w_en), .wr_data(w_data),
    .wr_tag(w_tag), .ev_good(ev_good), .ev_bad(ev_bad)
  );

  hdlc_rx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(10), .NF_LEVEL(NF_LEVEL)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(w_en), .wr_data({w_tag, w_data}),
    .rd_en(rd_en), .rd_q(r_q), .rd_vld(rd_valid), .empty(fifo_empty),
    .near_full(near_full), .ovf(ovf)
  );

  assign rd_data = r_q[7:0];
  assign rd_tag  = r_q[9:8];

  always_comb begin
    irq_set          = '0;
    irq_set[IRQ_NF]  = near_full;
    irq_set[IRQ_OVF] = ovf;
    irq_set[IRQ_EOP] = ev_good;
    irq_set[IRQ_BAD] = ev_bad;
  end

  for (genvar i = 0; i < IRQ_N; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) irq_stat[i] <= 1'b0;
      else     irq_stat[i] <= (irq_stat[i] && !irq_clr[i]) || irq_set[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(irq_stat & irq_mask);
  end

  // R9: a bad-frame event is latched into its source bit
  p_bad_latch_r9: assert property (@(posedge clk) disable iff (rst)
    ev_bad |=> irq_stat[IRQ_BAD]);
  // R9: a source bit falls only through a clear
  p_clear_only_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_stat[IRQ_EOP]) |-> $past(irq_clr[IRQ_EOP]));
endmodule

// File: tb/tb_hdlc_rx_frame.sv
module tb_hdlc_rx_frame;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_en = 1'b0, rx_bit = 1'b1;
  logic [1:0] addr_mode = 2'd0;
  logic [7:0] addr0 = 8'h31, addr1 = 8'h42;
  logic rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [1:0] rd_tag;
  logic rd_valid, fifo_empty, irq;
  logic [3:0] irq_mask = 4'h0, irq_clr = 4'h0, irq_stat;

  int errors = 0, checks = 0, ones = 0;
  bit done = 1'b0;
  logic [15:0] tcrc;
  logic [7:0] fbuf [0:7];

  always #10 clk = ~clk;

  hdlc_rx_frame dut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rx_bit(rx_bit), .addr_mode(addr_mode),
    .addr0(addr0), .addr1(addr1), .rd_en(rd_en), .rd_data(rd_data), .rd_tag(rd_tag),
    .rd_valid(rd_valid), .fifo_empty(fifo_empty), .irq_mask(irq_mask),
    .irq_clr(irq_clr), .irq_stat(irq_stat), .irq(irq)
  );

  // mode(2) b0 b1 b2 b3 keep(1)
  localparam logic [34:0] VEC [8] = '{
    {2'd0, 8'h7E, 8'hFF, 8'h3F, 8'h1F, 1'b1},
    {2'd1, 8'h31, 8'h22, 8'h33, 8'h44, 1'b1},
    {2'd1, 8'h30, 8'h22, 8'h33, 8'h44, 1'b0},
    {2'd1, 8'hFF, 8'h00, 8'hFF, 8'h80, 1'b1},
    {2'd2, 8'h31, 8'h42, 8'h55, 8'hAA, 1'b1},
    {2'd2, 8'h31, 8'h43, 8'h55, 8'hAA, 1'b0},
    {2'd3, 8'hFF, 8'h00, 8'h01, 8'h02, 1'b1},
    {2'd2, 8'h30, 8'h42, 8'h01, 8'h02, 1'b0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_raw(input logic b);
    @(negedge clk); rx_en = 1'b1; rx_bit = b;
    @(negedge clk); rx_en = 1'b0; rx_bit = ~b;
  endtask

  task automatic put_data(input logic b);
    put_raw(b);
    tcrc = tcrc[0] ^ b ? ((tcrc >> 1) ^ 16'h8408) : (tcrc >> 1);
    if (b) begin
      ones++;
      if (ones == 5) begin put_raw(1'b0); ones = 0; end
    end else ones = 0;
  endtask

  task automatic put_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) put_data(v[i]);
  endtask

  task automatic put_flag();
    put_raw(1'b0);
    for (int i = 0; i < 6; i++) put_raw(1'b1);
    put_raw(1'b0);
    ones = 0;
  endtask

  task automatic send_frame(input int n, input bit fcs, input bit corrupt, input int extra);
    logic [15:0] f;
    put_flag(); put_flag();
    tcrc = 16'hFFFF;
    for (int i = 0; i < n; i++) put_byte(fbuf[i]);
    for (int i = 0; i < extra; i++) put_data(i[0]);
    if (fcs) begin
      f = ~tcrc;
      if (corrupt) f[3] = ~f[3];
      fbuf[n] = f[7:0]; fbuf[n+1] = f[15:8];
      put_byte(f[7:0]); put_byte(f[15:8]);
    end
    put_flag(); put_flag(); put_flag();
    repeat (10) @(negedge clk);
  endtask

  task automatic pop(output logic [7:0] d, output logic [1:0] t, output logic v);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    d = rd_data; t = rd_tag; v = rd_valid;
  endtask

  task automatic expect_frame(input int n, input logic [1:0] last, input string req);
    logic [7:0] d; logic [1:0] t; logic v;
    for (int i = 0; i < n; i++) begin
      pop(d, t, v);
      check(v && d == fbuf[i], req, int'(d), int'(fbuf[i]));
      check(t == ((i == n - 1) ? last : 2'b00), req, int'(t), int'((i == n - 1) ? last : 2'b00));
    end
    @(negedge clk);
    check(fifo_empty, req, int'(fifo_empty), 1);
  endtask

  task automatic clear_all();
    @(negedge clk); irq_clr = 4'hF;
    @(negedge clk); irq_clr = 4'h0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d; logic [1:0] t; logic v; int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    check(fifo_empty, "reset R8", int'(fifo_empty), 1);
    check(irq_stat == 4'h0, "reset R9", int'(irq_stat), 0);
    check(!irq, "reset R9", int'(irq), 0);
    check(!rd_valid, "reset R8", int'(rd_valid), 0);

    // vector table: R1 R5 R6 R7 R10 (line gated by rx_en, garbage in idle cycles)
    for (int k = 0; k < 8; k++) begin
      addr_mode = VEC[k][34:33];
      fbuf[0] = VEC[k][32:25]; fbuf[1] = VEC[k][24:17];
      fbuf[2] = VEC[k][16:9];  fbuf[3] = VEC[k][8:1];
      send_frame(4, 1'b1, 1'b0, 0);
      if (VEC[k][0]) expect_frame(6, 2'b01, "R1 R5 R6 R7 R10 vector");
      else check(fifo_empty, "R7 reject", int'(fifo_empty), 1);
    end
    // R9: source set while masked keeps irq low
    check(irq_stat[2], "R9 eop source", int'(irq_stat), 4);
    check(!irq_stat[3], "R9 no bad source", int'(irq_stat), 4);
    check(!irq, "R9 masked", int'(irq), 0);
    @(negedge clk); irq_mask = 4'b0100;
    repeat (3) @(negedge clk);
    check(irq, "R9 unmasked", int'(irq), 1);
    clear_all();
    repeat (2) @(negedge clk);
    check(irq_stat == 4'h0 && !irq, "R9 clear", int'(irq_stat), 0);
    irq_mask = 4'hF;
    addr_mode = 2'd0;

    // R3: 24-bit frame vanishes
    fbuf[0] = 8'h11; fbuf[1] = 8'h22; fbuf[2] = 8'h33; fbuf[3] = 8'h44;
    send_frame(3, 1'b0, 1'b0, 0);
    check(fifo_empty, "R3 short frame", int'(fifo_empty), 1);
    check(irq_stat == 4'h0, "R3 no irq", int'(irq_stat), 0);

    // R4: 28-bit frame kept and tagged bad
    send_frame(3, 1'b0, 1'b0, 4);
    check(irq_stat[3], "R4 bad source", int'(irq_stat), 8);
    expect_frame(3, 2'b10, "R4 runt");
    clear_all();

    // R5: corrupted FCS
    send_frame(4, 1'b1, 1'b1, 0);
    check(irq_stat[3] && !irq_stat[2], "R5 bad fcs source", int'(irq_stat), 8);
    expect_frame(6, 2'b10, "R5 bad fcs");
    clear_all();

    // R11 R2: abort after six bytes
    for (int i = 0; i < 6; i++) fbuf[i] = 8'(i + 1);
    put_flag(); put_flag(); tcrc = 16'hFFFF;
    for (int i = 0; i < 6; i++) put_byte(fbuf[i]);
    for (int i = 0; i < 8; i++) put_raw(1'b1);
    put_flag(); put_flag();
    repeat (10) @(negedge clk);
    check(irq_stat[3] && irq, "R11 abort irq", int'(irq_stat), 8);
    expect_frame(5, 2'b10, "R11 R2 abort");
    clear_all();

    // R8: six 6-entry frames overflow the 32-entry FIFO
    fbuf[0] = 8'hA5; fbuf[1] = 8'h5A; fbuf[2] = 8'hC3; fbuf[3] = 8'h3C;
    for (int k = 0; k < 6; k++) send_frame(4, 1'b1, 1'b0, 0);
    check(irq_stat[0], "R8 nearly full", int'(irq_stat), 1);
    check(irq_stat[1], "R8 overflow", int'(irq_stat), 2);
    n = 0;
    while (!fifo_empty && n < 40) begin
      pop(d, t, v);
      check(v && d == fbuf[n % 6], "R8 kept order", int'(d), int'(fbuf[n % 6]));
      n++;
    end
    check(n == 32, "R8 depth", n, 32);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule